// File: doc/BRIEF.md
# UDP Frame Packetizer with Response/Stream Arbitration

This block turns two kinds of outgoing traffic into complete Ethernet/IPv4/UDP frames and merges them onto one transmit byte stream. Short command replies come from the waveform logic through a valid/ready byte interface. Receive-side sample bytes arrive one per cycle with no back-pressure and are collected in an internal buffer. The block places a 42-byte header in front of every payload. The header holds a 14-byte MAC header, a 20-byte IPv4 header and an 8-byte UDP header, with the length fields and the IPv4 header checksum computed from the payload size.

A sequencer picks the next frame only at a frame boundary, so two frames never interleave. A waiting reply takes precedence over buffered samples. A sample frame is started only when a whole payload is already buffered. Addresses and port numbers come from configuration inputs, which are expected to stay constant while frames are in flight. Both payload sizes and the buffer depth are parameters. The defaults give 60-byte reply frames (18-byte payload) and 557-byte sample frames (515-byte payload).

Top module: `pktarb_top`

## Requirements
- R1: While reset is held, txValid is low and ovfSticky is low.
- R2: Every frame is exactly 42 header bytes followed by the payload: RSP_LEN bytes for a reply, STR_LEN bytes for a sample frame (defaults give 60 and 557 bytes). txLast is high only with txValid and only on the final payload byte.
- R3: Header bytes, most significant byte first, in this order:
  - bytes 0-5: destination MAC.
  - bytes 6-11: source MAC.
  - bytes 12-13: 0x0800.
  - bytes 14-15: 0x45, 0x00.
  - bytes 18-19: identification, 0x0000.
  - bytes 20-21: 0x4000, don't-fragment.
  - byte 22: TTL 0x40.
  - byte 23: protocol 0x11.
  - bytes 26-29: source IP.
  - bytes 30-33: destination IP.
  - bytes 34-35: source port.
  - bytes 36-37: destination port, cfgRspDstPort for replies and cfgStrDstPort for sample frames.
  - bytes 40-41: UDP checksum, sent as 0x0000.
- R4: Bytes 16-17 carry the IPv4 total length, which is payload length + 28. Bytes 38-39 carry the UDP length, which is payload length + 8.
- R5: Bytes 24-25 carry the ones'-complement of the ones'-complement sum of the ten 16-bit header words in bytes 14-33, with the checksum word counted as zero.
- R6: The sequencer spends exactly one idle cycle (txValid low) between frames. In that cycle a high rspValid starts a reply frame on the next cycle. Otherwise a sample frame starts if at least STR_LEN bytes are buffered. A frame in progress is always finished first.
- R7: A sample frame's payload is the oldest STR_LEN buffered sample bytes, in arrival order.
- R8: While txValid is high and txReady is low in the header or in a sample payload, txData, txLast and txValid hold their values into the next cycle.
- R9: Reply payload bytes pass from rspData to txData. rspReady is high exactly when a reply payload byte is accepted (txValid and txReady). If rspValid is low during a reply payload, txValid is low.
- R10: A sample that arrives while FIFO_DEPTH bytes are held is dropped, even in a cycle where a byte leaves. This sets ovfSticky, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSrcMac | input | 48 | Source MAC address |
| cfgDstMac | input | 48 | Destination MAC address |
| cfgSrcIp | input | 32 | Source IPv4 address |
| cfgDstIp | input | 32 | Destination IPv4 address |
| cfgSrcPort | input | 16 | UDP source port |
| cfgRspDstPort | input | 16 | UDP destination port for reply frames |
| cfgStrDstPort | input | 16 | UDP destination port for sample frames |
| rspValid | input | 1 | Reply byte available |
| rspData | input | 8 | Reply payload byte |
| rspReady | output | 1 | Reply byte taken this cycle |
| smpValid | input | 1 | Sample byte present this cycle |
| smpData | input | 8 | Sample byte |
| txValid | output | 1 | Output byte valid |
| txData | output | 8 | Output byte |
| txLast | output | 1 | Final byte of frame |
| txReady | input | 1 | Downstream accepts byte |
| ovfSticky | output | 1 | Sample buffer overflow seen |

## Verification
A wrong header counter or phase shows up as a wrong txData byte, or a misplaced txLast, in the cycle the counter goes wrong. A wrong buffer occupancy first shows in the idle cycle between frames: a sample frame starts one frame too early or too late, and txValid disagrees with the reference right away. A corrupt read pointer shows as a wrong payload byte on the next accepted sample byte. A lost or spurious overflow shows on ovfSticky in the cycle after the offending sample. The reference model is compared on every clock, so any of these is caught within one cycle of reaching the ports.

// File: rtl/pktarb_pkg.sv
package pktarb_pkg;
  localparam int HDR_BYTES = 42;

  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_PAY} phase_t;

  typedef struct packed {
    logic       selHdr;
    logic       selRsp;
    logic       selFifo;
    logic       popFifo;
    logic       kindStr;
    logic [5:0] hdrIdx;
  } strobe_t;
endpackage

// File: rtl/pktarb_hdr.sv
module pktarb_hdr
  import pktarb_pkg::*;
#(
  parameter int RSP_LEN = 18,
  parameter int STR_LEN = 515
) (
  input  logic [47:0] cfgSrcMac,
  input  logic [47:0] cfgDstMac,
  input  logic [31:0] cfgSrcIp,
  input  logic [31:0] cfgDstIp,
  input  logic [15:0] cfgSrcPort,
  input  logic [15:0] cfgRspDstPort,
  input  logic [15:0] cfgStrDstPort,
  input  logic        kindStr,
  input  logic [5:0]  hdrIdx,
  output logic [7:0]  hdrByte
);
  localparam int HW = HDR_BYTES * 8;

  logic [15:0] payLen, ipLen, udpLen, dstPort, ipSum;
  logic [19:0] rawSum;
  logic [16:0] fold1;
  logic [16:0] fold2;
  logic [HW-1:0] hdrVec, shifted;

  always_comb begin
    payLen  = kindStr ? 16'(STR_LEN) : 16'(RSP_LEN);
    ipLen   = payLen + 16'd28;
    udpLen  = payLen + 16'd8;
    dstPort = kindStr ? cfgStrDstPort : cfgRspDstPort;
    // ones'-complement sum of the fixed and variable IPv4 header words
    rawSum  = 20'h04500 + 20'(ipLen) + 20'h04000 + 20'h04011
            + 20'(cfgSrcIp[31:16]) + 20'(cfgSrcIp[15:0])
            + 20'(cfgDstIp[31:16]) + 20'(cfgDstIp[15:0]);
    fold1   = 17'(rawSum[15:0]) + 17'(rawSum[19:16]);
    fold2   = 17'(fold1[15:0]) + 17'(fold1[16]);
    ipSum   = ~fold2[15:0];
    hdrVec  = {cfgDstMac, cfgSrcMac, 16'h0800,
               8'h45, 8'h00, ipLen, 16'h0000, 16'h4000, 8'h40, 8'h11, ipSum,
               cfgSrcIp, cfgDstIp,
               cfgSrcPort, dstPort, udpLen, 16'h0000};
    shifted = hdrVec << {hdrIdx, 3'b000};
    hdrByte = shifted[HW-1 -: 8];
  end
endmodule

// File: rtl/pktarb_ctrl.sv
module pktarb_ctrl
  import pktarb_pkg::*;
#(
  parameter int RSP_LEN = 18,
  parameter int STR_LEN = 515
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rspValid,
  input  logic    streamAvail,
  input  logic    txReady,
  output strobe_t strb,
  output logic    txValid,
  output logic    txLast,
  output logic    rspReady
);
  localparam int MAXLEN = (STR_LEN > RSP_LEN) ? STR_LEN : RSP_LEN;
  localparam int SPAN   = (MAXLEN > HDR_BYTES) ? MAXLEN : HDR_BYTES;
  localparam int CW     = $clog2(SPAN);

  phase_t        phase;
  logic          kindStr;
  logic [CW-1:0] cnt, payEnd;
  logic          fire, hdrEnd, payDone;

  always_comb begin
    payEnd  = kindStr ? CW'(STR_LEN - 1) : CW'(RSP_LEN - 1);
    txValid = (phase == PH_HDR) || ((phase == PH_PAY) && (kindStr || rspValid));
    fire    = txValid && txReady;
    hdrEnd  = (phase == PH_HDR) && (cnt == CW'(HDR_BYTES - 1));
    payDone = (phase == PH_PAY) && (cnt == payEnd);
    txLast  = txValid && payDone;
    rspReady = fire && (phase == PH_PAY) && !kindStr;

    strb.selHdr  = (phase == PH_HDR);
    strb.selRsp  = (phase == PH_PAY) && !kindStr;
    strb.selFifo = (phase == PH_PAY) && kindStr;
    strb.popFifo = fire && (phase == PH_PAY) && kindStr;
    strb.kindStr = kindStr;
    strb.hdrIdx  = cnt[5:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      kindStr <= 1'b0;
      cnt     <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (rspValid) begin
            phase   <= PH_HDR;
            kindStr <= 1'b0;
          end else if (streamAvail) begin
            phase   <= PH_HDR;
            kindStr <= 1'b1;
          end
        end
        PH_HDR: if (fire) begin
          if (hdrEnd) begin
            phase <= PH_PAY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_PAY: if (fire) begin
          if (payDone) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_RSP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && rspValid) |=> (phase == PH_HDR && !kindStr)); // R6
  AST_HDR_TO_PAY: assert property (@(posedge clk) disable iff (!rstN)
    (hdrEnd && fire) |=> (phase == PH_PAY && cnt == '0)); // R2
endmodule

// File: rtl/pktarb_dpath.sv
module pktarb_dpath
  import pktarb_pkg::*;
#(
  parameter int RSP_LEN    = 18,
  parameter int STR_LEN    = 515,
  parameter int FIFO_DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic [47:0] cfgSrcMac,
  input  logic [47:0] cfgDstMac,
  input  logic [31:0] cfgSrcIp,
  input  logic [31:0] cfgDstIp,
  input  logic [15:0] cfgSrcPort,
  input  logic [15:0] cfgRspDstPort,
  input  logic [15:0] cfgStrDstPort,
  input  logic [7:0]  rspData,
  input  logic        smpValid,
  input  logic [7:0]  smpData,
  output logic [7:0]  txData,
  output logic        streamAvail,
  output logic        ovfSticky
);
  localparam int AW = $clog2(FIFO_DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [FIFO_DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          full, push;
  logic [7:0]    hdrByte;

  pktarb_hdr #(.RSP_LEN(RSP_LEN), .STR_LEN(STR_LEN)) u_hdr (
    .cfgSrcMac(cfgSrcMac), .cfgDstMac(cfgDstMac),
    .cfgSrcIp(cfgSrcIp), .cfgDstIp(cfgDstIp),
    .cfgSrcPort(cfgSrcPort), .cfgRspDstPort(cfgRspDstPort),
    .cfgStrDstPort(cfgStrDstPort),
    .kindStr(strb.kindStr), .hdrIdx(strb.hdrIdx), .hdrByte(hdrByte)
  );

  always_comb begin
    full        = (count == CW'(FIFO_DEPTH));
    push        = smpValid && !full;
    streamAvail = (count >= CW'(STR_LEN));
    if (strb.selHdr)       txData = hdrByte;
    else if (strb.selFifo) txData = mem[rdPtr];
    else if (strb.selRsp)  txData = rspData;
    else                   txData = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= smpData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      ovfSticky <= 1'b0;
    end else begin
      if (push)
        wrPtr <= (wrPtr == AW'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strb.popFifo)
        rdPtr <= (rdPtr == AW'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      unique case ({push, strb.popFifo})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (smpValid && full) ovfSticky <= 1'b1;
    end
  end

  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.popFifo |-> (count != '0)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfSticky |=> ovfSticky); // R10
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !strb.popFifo) |=> full); // R10
endmodule

// File: rtl/pktarb_top.sv
module pktarb_top
  import pktarb_pkg::*;
#(
  parameter int RSP_LEN    = 18,
  parameter int STR_LEN    = 515,
  parameter int FIFO_DEPTH = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [47:0] cfgSrcMac,
  input  logic [47:0] cfgDstMac,
  input  logic [31:0] cfgSrcIp,
  input  logic [31:0] cfgDstIp,
  input  logic [15:0] cfgSrcPort,
  input  logic [15:0] cfgRspDstPort,
  input  logic [15:0] cfgStrDstPort,
  input  logic        rspValid,
  input  logic [7:0]  rspData,
  output logic        rspReady,
  input  logic        smpValid,
  input  logic [7:0]  smpData,
  output logic        txValid,
  output logic [7:0]  txData,
  output logic        txLast,
  input  logic        txReady,
  output logic        ovfSticky
);
  strobe_t strb;
  logic    streamAvail;

  pktarb_ctrl #(.RSP_LEN(RSP_LEN), .STR_LEN(STR_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .rspValid(rspValid), .streamAvail(streamAvail),
    .txReady(txReady), .strb(strb), .txValid(txValid), .txLast(txLast),
    .rspReady(rspReady)
  );

  pktarb_dpath #(.RSP_LEN(RSP_LEN), .STR_LEN(STR_LEN), .FIFO_DEPTH(FIFO_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgSrcMac(cfgSrcMac), .cfgDstMac(cfgDstMac),
    .cfgSrcIp(cfgSrcIp), .cfgDstIp(cfgDstIp),
    .cfgSrcPort(cfgSrcPort), .cfgRspDstPort(cfgRspDstPort),
    .cfgStrDstPort(cfgStrDstPort),
    .rspData(rspData), .smpValid(smpValid), .smpData(smpData),
    .txData(txData), .streamAvail(streamAvail), .ovfSticky(ovfSticky)
  );

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !strb.selRsp) |=>
      (txValid && $stable(txData) && $stable(txLast))); // R8
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid); // R2
  AST_RSP_HANDSHAKE: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> (txValid && txReady && rspValid)); // R9
endmodule

// File: tb/test_pktarb_top.sv
module test_pktarb_top;
  localparam int RSPL  = 18;
  localparam int STRL  = 515;
  localparam int DEPTH = 600;

  localparam logic [47:0] C_SMAC = 48'h02_A1_B2_C3_D4_E5;
  localparam logic [47:0] C_DMAC = 48'h06_10_20_30_40_50;
  localparam logic [31:0] C_SIP  = 32'hC0A8_0A07;
  localparam logic [31:0] C_DIP  = 32'hC0A8_0A64;
  localparam logic [15:0] C_SPRT = 16'd5001;
  localparam logic [15:0] C_RPRT = 16'd6002;
  localparam logic [15:0] C_SPRT2 = 16'd7003;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rspValid = 1'b0;
  logic [7:0] rspData = 8'h5A;
  logic smpValid = 1'b0;
  logic [7:0] smpData = 8'h00;
  logic txReady = 1'b0;
  logic rspReady, txValid, txLast, ovfSticky;
  logic [7:0] txData;

  always #4 clk = ~clk;

  pktarb_top #(.RSP_LEN(RSPL), .STR_LEN(STRL), .FIFO_DEPTH(DEPTH)) i_pktarb_top (
    .clk(clk), .rstN(rstN),
    .cfgSrcMac(C_SMAC), .cfgDstMac(C_DMAC), .cfgSrcIp(C_SIP), .cfgDstIp(C_DIP),
    .cfgSrcPort(C_SPRT), .cfgRspDstPort(C_RPRT), .cfgStrDstPort(C_SPRT2),
    .rspValid(rspValid), .rspData(rspData), .rspReady(rspReady),
    .smpValid(smpValid), .smpData(smpData),
    .txValid(txValid), .txData(txData), .txLast(txLast), .txReady(txReady),
    .ovfSticky(ovfSticky)
  );

  int nTests = 0;
  int nFail = 0;
  int cyc = 0;
  int rdyMode = 0;
  int rspRequested = 0, rspStarted = 0, rspLeft = 0;
  int smpRequested = 0, smpSent = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // stimulus drivers
  always @(posedge clk) begin
    cyc <= cyc + 1;
    txReady <= (rdyMode == 0) ? 1'b1 : (rdyMode == 1) ? ((cyc % 3) != 0) : 1'b0;
    if (smpSent < smpRequested) begin
      smpValid <= 1'b1;
      smpData  <= 8'(smpSent * 7 + 3);
      smpSent  <= smpSent + 1;
    end else begin
      smpValid <= 1'b0;
    end
    if (rspValid && rspReady) begin
      rspData <= rspData + 8'd13;
      if (rspLeft == 1) rspValid <= 1'b0;
      rspLeft <= rspLeft - 1;
    end else if (!rspValid && rspStarted < rspRequested) begin
      rspValid   <= 1'b1;
      rspLeft    <= RSPL;
      rspStarted <= rspStarted + 1;
    end
  end

  function automatic logic [7:0] expHdr(input int idx, input bit str);
    logic [7:0] hb [42];
    logic [15:0] plen, prt;
    int sum;
    plen = str ? 16'(STRL) : 16'(RSPL);
    prt  = str ? C_SPRT2 : C_RPRT;
    for (int k = 0; k < 42; k++) hb[k] = 8'h00;
    for (int k = 0; k < 6; k++) begin
      hb[k]     = C_DMAC[47 - 8*k -: 8];
      hb[6 + k] = C_SMAC[47 - 8*k -: 8];
    end
    hb[12] = 8'h08;
    hb[14] = 8'h45;
    {hb[16], hb[17]} = plen + 16'd28;
    hb[20] = 8'h40;
    hb[22] = 8'h40;
    hb[23] = 8'h11;
    for (int k = 0; k < 4; k++) begin
      hb[26 + k] = C_SIP[31 - 8*k -: 8];
      hb[30 + k] = C_DIP[31 - 8*k -: 8];
    end
    {hb[34], hb[35]} = C_SPRT;
    {hb[36], hb[37]} = prt;
    {hb[38], hb[39]} = plen + 16'd8;
    sum = 0;
    for (int w = 0; w < 10; w++) sum += int'({hb[14 + 2*w], hb[15 + 2*w]});
    while (sum > 32'hFFFF) sum = (sum & 32'hFFFF) + (sum >>> 16);
    {hb[24], hb[25]} = ~16'(sum);
    return hb[idx];
  endfunction

  // behavioural reference model, compared every cycle
  int mPh = 0, mIdx = 0, frameBytes = 0;
  bit mStr = 1'b0, mOvf = 1'b0, prevStall = 1'b0;
  logic [7:0] prevData = 8'h00;
  logic [7:0] sq[$];

  always @(negedge clk) begin
    bit expValid, expLast, expRdy, fire, full;
    int len, sizeBefore;
    logic [7:0] expData;
    string dreq;
    if (!rstN) begin
      mPh = 0; mIdx = 0; mStr = 0; mOvf = 0; prevStall = 0; frameBytes = 0;
      sq.delete();
      if (cyc > 0) begin
        chk(txValid == 1'b0, "R1", "txValid in reset", int'(txValid), 0);
        chk(ovfSticky == 1'b0, "R1", "ovfSticky in reset", int'(ovfSticky), 0);
      end
    end else begin
      len      = mStr ? STRL : RSPL;
      expValid = (mPh == 1) || (mPh == 2 && (mStr || rspValid));
      expLast  = expValid && mPh == 2 && mIdx == len - 1;
      expRdy   = expValid && txReady && mPh == 2 && !mStr;
      expData  = (mPh == 1) ? expHdr(mIdx, mStr) : (mStr ? sq[0] : rspData);
      chk(txValid == expValid, "R6", "txValid", int'(txValid), int'(expValid));
      chk(txLast == expLast, "R2", "txLast", int'(txLast), int'(expLast));
      chk(rspReady == expRdy, "R9", "rspReady", int'(rspReady), int'(expRdy));
      chk(ovfSticky == mOvf, "R10", "ovfSticky", int'(ovfSticky), int'(mOvf));
      if (expValid) begin
        if (mPh == 1 && (mIdx == 16 || mIdx == 17 || mIdx == 38 || mIdx == 39)) dreq = "R4";
        else if (mPh == 1 && (mIdx == 24 || mIdx == 25)) dreq = "R5";
        else if (mPh == 1) dreq = "R3";
        else if (mStr) dreq = "R7";
        else dreq = "R9";
        chk(txData == expData, dreq, "txData", int'(txData), int'(expData));
      end
      if (prevStall)
        chk(txValid && txData == prevData, "R8", "held txData", int'(txData), int'(prevData));
      // advance model across the coming edge
      fire = expValid && txReady;
      sizeBefore = sq.size();
      full = (sizeBefore >= DEPTH);
      if (fire) begin
        frameBytes++;
        if (expLast) begin
          chk(frameBytes == 42 + len, "R2", "frame length", frameBytes, 42 + len);
          frameBytes = 0;
        end
      end
      if (fire && mPh == 2 && mStr) void'(sq.pop_front());
      if (smpValid) begin
        if (!full) sq.push_back(smpData);
        else mOvf = 1'b1;
      end
      case (mPh)
        0: begin
          mIdx = 0;
          if (rspValid) begin mPh = 1; mStr = 0; end
          else if (sizeBefore >= STRL) begin mPh = 1; mStr = 1; end
        end
        1: if (fire) begin
          if (mIdx == 41) begin mPh = 2; mIdx = 0; end
          else mIdx++;
        end
        default: if (fire) begin
          if (expLast) begin mPh = 0; mIdx = 0; end
          else mIdx++;
        end
      endcase
      prevStall = expValid && !txReady && !(mPh == 2 && !mStr);
      prevData  = txData;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    waitCycles(4);
    rstN = 1'b1;
    // R2 R3 R4 R5 R9: single reply, ready always high
    rdyMode = 0;
    rspRequested = 1;
    waitCycles(90);
    // R8 R9: two replies under back-pressure
    rdyMode = 1;
    rspRequested = 3;
    waitCycles(250);
    // R7: one full sample payload
    rdyMode = 0;
    smpRequested = STRL;
    waitCycles(STRL + 700);
    // R6: replies arrive while samples keep streaming under back-pressure
    rdyMode = 1;
    smpRequested = smpRequested + 1200;
    waitCycles(300);
    rspRequested = 5;
    waitCycles(3000);
    // R10: ready held low while samples overflow the buffer
    rdyMode = 2;
    smpRequested = smpRequested + DEPTH + 100;
    waitCycles(DEPTH + 200);
    chk(ovfSticky == 1'b1, "R10", "overflow after flood", int'(ovfSticky), 1);
    rdyMode = 0;
    waitCycles(2500);
    chk(txValid == 1'b0, "R6", "idle after drain", int'(txValid), 0);
    chk(ovfSticky == 1'b1, "R10", "sticky after drain", int'(ovfSticky), 1);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule